// File: doc/BRIEF.md
# Hold-Flag Reseeding Scan Decompressor

This block turns one stored 16-bit seed into the scan-in bit stream of one test cube for test-per-scan self-test. A start command copies the seed into a linear feedback shift register, which then runs freely. The cube is cut into equal blocks of scan bits. At the head of every block the register gives up one bit as a hold flag. A flag of one opens a transition block, whose scan bits come straight from the register. A flag of zero opens a hold block, in which the scan-in level stays frozen and the register pauses. Blocks without transitions therefore shift a constant value, which lowers switching in the scan chain.

The scan output is a stream. `scan_en` acts as valid and `scan_ready` as ready, and a bit moves only in a cycle where both are high. While `scan_en` is high and `scan_ready` is low, `scan_si` and all internal progress hold still. The stream never withdraws a bit it has offered. Flag cycles do not wait for ready, and the hold-flag blocks and data bits both come from the same register sequence.

Top module: `hfr_scan_expander`

## Requirements
- R1: When `busy` is low, a `seed_load` pulse stores `seed_data` as the seed, and an all-zero value is stored as 16'h0001. While `busy` is high, `seed_load` has no effect.
- R2: When `busy` is low, `start` copies the stored seed into the register and raises `busy` in the next cycle. While `busy` is high, `start` has no effect.
- R3: The register's output bit is state[15]. One step moves the state to {state[14:0], state[15]^state[13]^state[12]^state[10]}.
- R4: Each block opens with exactly one flag cycle. In that cycle the output bit is taken as the flag, the register steps once, and `scan_en` is low.
- R5: In a block whose flag is 1, each of the BLK_LEN accepted beats carries the current output bit, and the register steps after each accepted beat.
- R6: In a block whose flag is 0, all BLK_LEN beats carry the last scan bit sent, so `scan_si` never toggles inside the block, and the register does not step.
- R7: The held level is 0 at the start of every cube.
- R8: While `scan_en` is high and `scan_ready` is low, `scan_en` stays high and `scan_si` stays unchanged in the next cycle.
- R9: A cube is CUBE_LEN/BLK_LEN blocks and CUBE_LEN accepted beats. `done` is high for exactly the one cycle after the last accepted beat, and `busy` is low in that cycle.
- R10: During and right after reset, `busy`, `done` and `scan_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seed_load | input | 1 | Store `seed_data` as the seed while idle |
| seed_data | input | 16 | Seed value |
| start | input | 1 | Begin one cube while idle |
| busy | output | 1 | A cube is being expanded |
| done | output | 1 | One-cycle pulse after the final beat |
| scan_si | output | 1 | Scan-in data bit |
| scan_en | output | 1 | Scan enable, and valid for `scan_si` |
| scan_ready | input | 1 | Scan chain accepts the bit this cycle |

## Verification
The bench compares the full cube against a software model for seeds whose first flag is zero or one, and for the zero seed. A design that dropped the zero-seed guard would emit a dead stream. One that kept stepping the register in hold blocks would drift from the model at the first transition block after a hold.

Ready patterns with sparse and dense stalls check that a stalled beat neither changes nor gets counted twice. Mid-cube `start` and `seed_load` pulses must leave both the current cube and the next one unchanged. The bench also counts flag cycles, beats and the timing of `done`, which catches off-by-one errors in the block and bit counters.

// File: rtl/hfr_pkg.sv
package hfr_pkg;
  localparam int LFSR_W = 16;
  // taps 16,14,13,11 -> state bits 15,13,12,10
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_FLAG  = 2'd1,
    PH_SHIFT = 2'd2
  } phase_t;
endpackage

// File: rtl/hfr_lfsr.sv
module hfr_lfsr
  import hfr_pkg::*;
#(
  parameter int W = LFSR_W,
  parameter logic [W-1:0] TAPS = LFSR_TAPS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic         out_bit,
  output logic [W-1:0] state
);
  logic [W-1:0] state_q;
  logic         fb;

  assign fb      = ^(state_q & TAPS);
  assign out_bit = state_q[W-1];
  assign state   = state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     state_q <= W'(1);
    else if (load)  state_q <= load_val;
    else if (step)  state_q <= {state_q[W-2:0], fb};
  end

  // R6: a paused register keeps its state
  a_r6_pause_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(state_q));
  // R3: maximal-length register loaded with a nonzero seed never reaches zero
  a_r3_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);
endmodule

// File: rtl/hfr_block_seq.sv
module hfr_block_seq
  import hfr_pkg::*;
#(
  parameter int BLK_LEN  = 8,
  parameter int CUBE_LEN = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic lfsr_bit,
  input  logic scan_ready,
  output logic lfsr_load,
  output logic lfsr_step,
  output logic scan_en,
  output logic scan_si,
  output logic busy,
  output logic done
);
  localparam int NBLK = CUBE_LEN / BLK_LEN;
  localparam int BW   = (BLK_LEN > 1) ? $clog2(BLK_LEN) : 1;
  localparam int KW   = (NBLK > 1) ? $clog2(NBLK) : 1;

  phase_t        phase_q;
  logic [BW-1:0] bit_q;
  logic [KW-1:0] blk_q;
  logic          flag_q, held_q, done_q;
  logic          beat, last_bit, last_blk, idle;

  assign idle      = (phase_q == PH_IDLE);
  assign last_bit  = (bit_q == BW'(BLK_LEN - 1));
  assign last_blk  = (blk_q == KW'(NBLK - 1));
  assign scan_en   = (phase_q == PH_SHIFT);
  assign beat      = scan_en && scan_ready;
  assign scan_si   = flag_q ? lfsr_bit : held_q;
  assign lfsr_load = idle && start;
  assign lfsr_step = (phase_q == PH_FLAG) || (beat && flag_q);
  assign busy      = !idle;
  assign done      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      bit_q   <= '0;
      blk_q   <= '0;
      flag_q  <= 1'b0;
      held_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (start) begin
          phase_q <= PH_FLAG;
          blk_q   <= '0;
          held_q  <= 1'b0;
          flag_q  <= 1'b0;
        end
        PH_FLAG: begin
          flag_q  <= lfsr_bit;
          bit_q   <= '0;
          phase_q <= PH_SHIFT;
        end
        PH_SHIFT: if (scan_ready) begin
          held_q <= scan_si;
          if (last_bit) begin
            if (last_blk) begin
              phase_q <= PH_IDLE;
              done_q  <= 1'b1;
            end else begin
              phase_q <= PH_FLAG;
              blk_q   <= blk_q + KW'(1);
            end
          end else begin
            bit_q <= bit_q + BW'(1);
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  // R2: an idle start makes the block busy
  a_r2_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  // R4: a finished block is followed by a flag cycle, not a beat
  a_r4_flag_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && last_bit) |=> !scan_en);
  // R6: inside a hold block the bit repeats
  a_r6_hold_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !flag_q && !last_bit) |=> (scan_si == $past(scan_si)));
  // R8: a stalled beat stays offered and unchanged
  a_r8_stall_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && !scan_ready) |=> (scan_en && $stable(scan_si)));
  // R9: done is a single pulse while idle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !scan_en));
endmodule

// File: rtl/hfr_scan_expander.sv
module hfr_scan_expander
  import hfr_pkg::*;
#(
  parameter int BLK_LEN  = 8,
  parameter int CUBE_LEN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seed_load,
  input  logic [LFSR_W-1:0] seed_data,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              scan_si,
  output logic              scan_en,
  input  logic              scan_ready
);
  logic [LFSR_W-1:0] seed_q;
  logic [LFSR_W-1:0] lfsr_state;
  logic              lfsr_bit, lfsr_load, lfsr_step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  seed_q <= LFSR_W'(1);
    else if (seed_load && !busy) seed_q <= (seed_data == '0) ? LFSR_W'(1) : seed_data;
  end

  hfr_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS)) u_lfsr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (lfsr_load),
    .load_val (seed_q),
    .step     (lfsr_step),
    .out_bit  (lfsr_bit),
    .state    (lfsr_state)
  );

  hfr_block_seq #(.BLK_LEN(BLK_LEN), .CUBE_LEN(CUBE_LEN)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .lfsr_bit   (lfsr_bit),
    .scan_ready (scan_ready),
    .lfsr_load  (lfsr_load),
    .lfsr_step  (lfsr_step),
    .scan_en    (scan_en),
    .scan_si    (scan_si),
    .busy       (busy),
    .done       (done)
  );

  // R1: the stored seed is never zero
  a_r1_seed_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    seed_q != '0);
  // R1: seed is frozen while a cube runs
  a_r1_seed_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(seed_q));
  // R2: a start loads the register with the stored seed
  a_r2_seed_copied: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (lfsr_state == $past(seed_q)));
endmodule

// File: tb/test_hfr_scan_expander.sv
module test_hfr_scan_expander;
  localparam int B  = 8;
  localparam int L  = 64;
  localparam int NB = L / B;
  // {seed, stall mask}: mask bit n%16 set means ready low in that cycle
  localparam logic [31:0] VEC [7] = '{
    {16'hACE1, 16'h0000}, {16'h1234, 16'h0000}, {16'h7F00, 16'h00F0},
    {16'hFFFF, 16'h5555}, {16'h0F0F, 16'h8001}, {16'h4000, 16'h0000},
    {16'hC3A5, 16'hFFFE}
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, seed_load, start, scan_ready;
  logic [15:0] seed_data;
  logic        busy, done, scan_si, scan_en;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic exp_bit [L];
  logic exp_flag [NB];
  logic got_bit [L];
  int   got_n;

  hfr_scan_expander #(.BLK_LEN(B), .CUBE_LEN(L)) i_hfr_scan_expander (
    .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .seed_data(seed_data),
    .start(start), .busy(busy), .done(done), .scan_si(scan_si),
    .scan_en(scan_en), .scan_ready(scan_ready)
  );

  function automatic logic [15:0] adv(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic build_exp(input logic [15:0] seed_raw);
    logic [15:0] s;
    logic held;
    int k;
    s = (seed_raw == 16'h0) ? 16'h0001 : seed_raw;
    held = 1'b0;
    k = 0;
    for (int b = 0; b < NB; b++) begin
      exp_flag[b] = s[15];
      s = adv(s);
      for (int i = 0; i < B; i++) begin
        if (exp_flag[b]) begin exp_bit[k] = s[15]; s = adv(s); end
        else exp_bit[k] = held;
        held = exp_bit[k];
        k++;
      end
    end
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic run_cube(input logic [15:0] seed, input logic [15:0] mask,
                          input bit do_load, input bit inject);
    int flags, last_beat, done_at, bad, first_bad, tog;
    bit prev_stall;
    logic prev_si, lvl;
    if (do_load) begin
      @(negedge clk); seed_load = 1'b1; seed_data = seed;
      @(negedge clk); seed_load = 1'b0;
    end
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(busy === 1'b1, "R2", "busy after start", int'(busy), 1);
    got_n = 0; flags = 0; last_beat = -10; done_at = -1;
    prev_stall = 1'b0; prev_si = 1'b0;
    for (int n = 0; n < 4000 && done_at < 0; n++) begin
      if (done === 1'b1) begin
        done_at = n;
        check(busy === 1'b0, "R9", "busy during done", int'(busy), 0);
      end else begin
        if (prev_stall)
          check(scan_en === 1'b1 && scan_si === prev_si, "R8",
                "stalled bit changed", int'(scan_si), int'(prev_si));
        scan_ready = !mask[n % 16];
        if (inject && n == 10) begin
          seed_load = 1'b1; seed_data = 16'hBEEF; start = 1'b1;
        end else begin
          seed_load = 1'b0; start = 1'b0;
        end
        if (busy && !scan_en) flags++;
        if (scan_en && scan_ready) begin
          if (got_n < L) got_bit[got_n] = scan_si;
          got_n++;
          last_beat = n;
        end
        prev_stall = scan_en && !scan_ready;
        prev_si = scan_si;
        @(negedge clk);
      end
    end
    scan_ready = 1'b1; seed_load = 1'b0; start = 1'b0;
    check(done_at >= 0, "R9", "done seen", done_at, 1);
    check(done_at == last_beat + 1, "R9", "done cycle", done_at, last_beat + 1);
    check(got_n == L, "R9", "beat count", got_n, L);
    check(flags == NB, "R4", "flag cycle count", flags, NB);
    bad = 0; first_bad = -1;
    for (int i = 0; i < L && i < got_n; i++)
      if (got_bit[i] !== exp_bit[i]) begin
        bad++;
        if (first_bad < 0) first_bad = i;
      end
    check(bad == 0, "R3/R5", "stream mismatches (first index in log)", bad, 0);
    if (bad != 0) $display("  first mismatch index %0d", first_bad);
    tog = 0; lvl = 1'b0;
    for (int b = 0; b < NB; b++)
      for (int i = 0; i < B; i++) begin
        if (!exp_flag[b] && got_bit[b*B+i] !== lvl) tog++;
        lvl = got_bit[b*B+i];
      end
    check(tog == 0, "R6", "hold block toggles", tog, 0);
    if (!exp_flag[0])
      check(got_bit[0] === 1'b0 && got_bit[B-1] === 1'b0, "R7",
            "held level at cube start", int'(got_bit[0]), 0);
    @(negedge clk);
    check(done === 1'b0, "R9", "done width", int'(done), 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R9 watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; seed_load = 1'b0; start = 1'b0; scan_ready = 1'b1;
    seed_data = 16'h0;
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && scan_en === 1'b0, "R10",
          "outputs in reset", int'({busy, done, scan_en}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0 && scan_en === 1'b0, "R10",
          "outputs after reset", int'({busy, done, scan_en}), 0);

    for (int v = 0; v < 7; v++) begin
      build_exp(VEC[v][31:16]);
      run_cube(VEC[v][31:16], VEC[v][15:0], 1'b1, 1'b0);
    end

    // R1: zero seed behaves as seed 1
    build_exp(16'h0001);
    run_cube(16'h0000, 16'h0000, 1'b1, 1'b0);

    // R1/R2: seed_load and start during a cube are ignored
    build_exp(16'h1234);
    run_cube(16'h1234, 16'h0300, 1'b1, 1'b1);
    // R2: a new start reloads the kept seed, same cube again
    run_cube(16'h1234, 16'h0000, 1'b0, 1'b0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule